// File: doc/BRIEF.md
# Dual-Mode External Memory Bus Interface

This block turns single-cycle memory requests from a DSP core into activity on the chip's shared external pins. It serves four spaces: program, data, I/O and byte memory. A strap input is sampled while reset is held, and it chooses between two pin personalities. The choice stays in force until the next reset.

In full mode, the block drives a 14-bit word address and a 24-bit data bus. Byte-memory accesses use a 22-bit address that is split across the address pins and the top data byte. In host mode, the address pins [13:1] and the data pins [7:0] belong to a host DMA port, so the block never drives them. Only address bit 0 and data bits [23:8] remain for external traffic, and each select then reaches two word locations. A program-memory read in host mode cannot see the low byte, so that byte is filled with ones. The program-memory extension register is given to the core as `px_o`.

The data bus is split into output, per-bit enable and input. The board-level tristate buffer sits outside this block.

Top module: `ext_bus_iface`

## Requirements
- R1: The strap value present at the last clock edge with `rst_n` low sets `host_mode_o` (1 = host mode). Changes on the strap while `rst_n` is high have no effect.
- R2: A request accepted at a clock edge produces exactly one cycle of one active-low select, together with `rd_n_o` low (read) or `wr_n_o` low (write). When no request is accepted, all selects and both strobes are high. Space code 0 uses `sel_n_o[0]` (program), 1 uses bit 1 (data), 2 uses bit 2 (I/O) and 3 uses bit 3 (byte). Reset leaves all of them high.
- R3: In full mode, word accesses drive `req_addr[13:0]` on all 14 address pins. A program write drives all 24 bits of write data. A data or I/O write drives `req_wdata[15:0]` on data bits [23:8].
- R4: In full mode, a byte access drives `req_addr[13:0]` on the address pins and `req_addr[21:14]` on data bits [23:16]. A byte write also puts `req_wdata[7:0]` on data bits [15:8].
- R5: In host mode, address pins [13:1] and data pins [7:0] are never enabled. Address pin 0 carries `req_addr[0]`, and data or I/O writes put `req_wdata[15:0]` on data bits [23:8].
- R6: In host mode, a program write drives `req_wdata[23:8]` on data bits [23:8]. At the end of any program write, `px_o` takes `req_wdata[7:0]`.
- R7: In host mode, a program read returns `{data_i[23:8], 8'hFF}` and sets `px_o` to 8'hFF.
- R8: In host mode, a byte access drives `dm_page` on data bits [23:16] and the byte address parity `req_addr[0]` on address pin 0.
- R9: Data output enables are active only during a write strobe. The one exception is bits [23:16] during a byte access, which always carry address bits. Each read returns data one cycle after its strobe, with `rdata_valid_o` high for that cycle. Data and I/O reads return `{8'h0, data_i[23:8]}`, and byte reads return `{16'h0, data_i[15:8]}`.
- R10: In full mode, a program read returns all 24 bits of `data_i` and sets `px_o` to `data_i[7:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_strap | input | 1 | Pin personality strap, 1 = host mode |
| req_valid | input | 1 | Core access request this cycle |
| req_space | input | 2 | 0 program, 1 data, 2 I/O, 3 byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address in [13:0]; byte address in full width |
| req_wdata | input | 24 | Write data from the core |
| dm_page | input | 8 | Data-memory page value used for byte accesses in host mode |
| addr_o | output | 14 | External address pins |
| addr_oe_o | output | 14 | Per-bit address drive enable |
| data_o | output | 24 | Data bus output value |
| data_oe_o | output | 24 | Per-bit data bus drive enable |
| data_i | input | 24 | Data bus input value |
| sel_n_o | output | 4 | Active-low memory selects |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| rdata_o | output | 24 | Read data to the core |
| rdata_valid_o | output | 1 | Read data valid pulse |
| px_o | output | 8 | Program-memory extension register |
| host_mode_o | output | 1 | Latched personality, 1 = host mode |

## Verification
A request sampled at edge k shows on the selects, strobes, address and data pins from edge k until edge k+1. At edge k+1 the bus is captured. Read data, the valid pulse and the extension register update there and hold through the following cycle. The bench keeps a behavioural model that advances on each rising edge with exactly this one-cycle pin delay and two-cycle result delay. It compares every output on the falling edge, halfway between updates. Back-to-back requests make the result of one access and the pins of the next appear in the same cycle.

// File: rtl/ebi_pkg.sv
package ebi_pkg;
  localparam int DW   = 24;
  localparam int AW   = 14;
  localparam int BW   = 22;
  localparam int PW   = 8;
  localparam int NSEL = 4;
  localparam int HW   = DW - PW;

  typedef enum logic [1:0] {
    SP_PM = 2'd0,
    SP_DM = 2'd1,
    SP_IO = 2'd2,
    SP_BM = 2'd3
  } space_e;

  typedef struct packed {
    logic [AW-1:0]   addr;
    logic [AW-1:0]   aoe;
    logic [DW-1:0]   dout;
    logic [DW-1:0]   doe;
    logic [NSEL-1:0] sel_n;
  } pins_t;

  localparam pins_t PINS_IDLE = '{addr: '0, aoe: '0, dout: '0, doe: '0, sel_n: '1};

  // Pin image of one access in the selected personality.
  function automatic pins_t map_pins(input logic host, input space_e sp, input logic wr,
                                     input logic [BW-1:0] a, input logic [DW-1:0] wd,
                                     input logic [PW-1:0] page);
    pins_t p;
    p = PINS_IDLE;
    p.sel_n[sp] = 1'b0;
    if (host) begin
      p.addr[0] = a[0];
      p.aoe[0]  = 1'b1;
    end else begin
      p.addr = a[AW-1:0];
      p.aoe  = '1;
    end
    case (sp)
      SP_PM: if (wr) begin
        if (host) begin
          p.dout[DW-1:PW] = wd[DW-1:PW];
          p.doe[DW-1:PW]  = '1;
        end else begin
          p.dout = wd;
          p.doe  = '1;
        end
      end
      SP_DM, SP_IO: if (wr) begin
        p.dout[DW-1:PW] = wd[HW-1:0];
        p.doe[DW-1:PW]  = '1;
      end
      default: begin
        p.dout[DW-1:DW-PW] = host ? page : a[BW-1:AW];
        p.doe[DW-1:DW-PW]  = '1;
        if (wr) begin
          p.dout[DW-PW-1:PW] = wd[PW-1:0];
          p.doe[DW-PW-1:PW]  = '1;
        end
      end
    endcase
    return p;
  endfunction

  // Read data as seen by the core after the strobe.
  function automatic logic [DW-1:0] fmt_rdata(input logic host, input space_e sp,
                                              input logic [DW-1:0] din);
    logic [DW-1:0] r;
    case (sp)
      SP_PM:        r = host ? {din[DW-1:PW], {PW{1'b1}}} : din;
      SP_DM, SP_IO: r = {{PW{1'b0}}, din[DW-1:PW]};
      default:      r = {{HW{1'b0}}, din[DW-PW-1:PW]};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/ebi_mode_latch.sv
module ebi_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  output logic host
);
  always_ff @(posedge clk) begin
    if (!rst_n) host <= strap;
  end
endmodule

// File: rtl/ebi_pin_drive.sv
module ebi_pin_drive
  import ebi_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host,
  input  logic           req_valid,
  input  space_e         req_space,
  input  logic           req_write,
  input  logic [BW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [PW-1:0]  page,
  output pins_t          pins,
  output logic           rd_n,
  output logic           wr_n,
  output logic           acc_live,
  output space_e         acc_space,
  output logic           acc_write,
  output logic [PW-1:0]  acc_wlow
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins      <= PINS_IDLE;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      acc_live  <= 1'b0;
      acc_space <= SP_PM;
      acc_write <= 1'b0;
      acc_wlow  <= '0;
    end else if (req_valid) begin
      pins      <= map_pins(host, req_space, req_write, req_addr, req_wdata, page);
      rd_n      <= req_write;
      wr_n      <= !req_write;
      acc_live  <= 1'b1;
      acc_space <= req_space;
      acc_write <= req_write;
      acc_wlow  <= req_wdata[PW-1:0];
    end else begin
      pins      <= PINS_IDLE;
      rd_n      <= 1'b1;
      wr_n      <= 1'b1;
      acc_live  <= 1'b0;
    end
  end
endmodule

// File: rtl/ebi_rd_capture.sv
module ebi_rd_capture
  import ebi_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host,
  input  logic          acc_live,
  input  space_e        acc_space,
  input  logic          acc_write,
  input  logic [PW-1:0] acc_wlow,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [PW-1:0] px
);
  logic rd_end, pm_end;
  assign rd_end = acc_live && !acc_write;
  assign pm_end = acc_live && (acc_space == SP_PM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      px     <= '0;
    end else begin
      rvalid <= rd_end;
      if (rd_end) rdata <= fmt_rdata(host, acc_space, din);
      if (pm_end) px <= acc_write ? acc_wlow : (host ? {PW{1'b1}} : din[PW-1:0]);
    end
  end
endmodule

// File: rtl/ext_bus_iface.sv
module ext_bus_iface
  import ebi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_strap,
  input  logic            req_valid,
  input  logic [1:0]      req_space,
  input  logic            req_write,
  input  logic [BW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [PW-1:0]   dm_page,
  output logic [AW-1:0]   addr_o,
  output logic [AW-1:0]   addr_oe_o,
  output logic [DW-1:0]   data_o,
  output logic [DW-1:0]   data_oe_o,
  input  logic [DW-1:0]   data_i,
  output logic [NSEL-1:0] sel_n_o,
  output logic            rd_n_o,
  output logic            wr_n_o,
  output logic [DW-1:0]   rdata_o,
  output logic            rdata_valid_o,
  output logic [PW-1:0]   px_o,
  output logic            host_mode_o
);
  logic          host;
  pins_t         pins;
  logic          acc_live;
  space_e        acc_space;
  logic          acc_write;
  logic [PW-1:0] acc_wlow;

  ebi_mode_latch mode_i (
    .clk(clk), .rst_n(rst_n), .strap(mode_strap), .host(host)
  );

  ebi_pin_drive drive_i (
    .clk(clk), .rst_n(rst_n), .host(host),
    .req_valid(req_valid), .req_space(space_e'(req_space)), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .page(dm_page),
    .pins(pins), .rd_n(rd_n_o), .wr_n(wr_n_o),
    .acc_live(acc_live), .acc_space(acc_space), .acc_write(acc_write), .acc_wlow(acc_wlow)
  );

  ebi_rd_capture cap_i (
    .clk(clk), .rst_n(rst_n), .host(host),
    .acc_live(acc_live), .acc_space(acc_space), .acc_write(acc_write), .acc_wlow(acc_wlow),
    .din(data_i), .rdata(rdata_o), .rvalid(rdata_valid_o), .px(px_o)
  );

  assign addr_o      = pins.addr;
  assign addr_oe_o   = pins.aoe;
  assign data_o      = pins.dout;
  assign data_oe_o   = pins.doe;
  assign sel_n_o     = pins.sel_n;
  assign host_mode_o = host;
endmodule

// File: rtl/ebi_checker.sv
module ebi_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        host_mode,
  input logic [3:0]  sel_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic [13:0] aoe,
  input logic [23:0] doe,
  input logic        rvalid,
  input logic [7:0]  px
);
  AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1); // R2
  AST_STROBE_WITH_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n != 4'hF) |-> (rd_n != wr_n)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_n == 4'hF) |-> (rd_n && wr_n)); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(host_mode)); // R1
  AST_HOST_PINS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    host_mode |-> (aoe[13:1] == 13'h0 && doe[7:0] == 8'h0)); // R5
  AST_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_n |-> (doe[15:0] == 16'h0)); // R9
  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> rvalid); // R9
  AST_PX_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode && !sel_n[0] && !rd_n) |=> (px == 8'hFF)); // R7
endmodule

bind ext_bus_iface ebi_checker chk_i (
  .clk(clk), .rst_n(rst_n), .host_mode(host_mode_o), .sel_n(sel_n_o),
  .rd_n(rd_n_o), .wr_n(wr_n_o), .aoe(addr_oe_o), .doe(data_oe_o),
  .rvalid(rdata_valid_o), .px(px_o)
);

// File: tb/ext_bus_iface_tb.sv
module ext_bus_iface_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0, mode_strap = 1'b0, req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_space = 2'd0;
  logic [21:0] req_addr = '0;
  logic [23:0] req_wdata = '0, data_i = 24'h000123;
  logic [7:0]  dm_page = 8'h00;
  logic [13:0] addr_o, addr_oe_o;
  logic [23:0] data_o, data_oe_o, rdata_o;
  logic [3:0]  sel_n_o;
  logic        rd_n_o, wr_n_o, rdata_valid_o, host_mode_o;
  logic [7:0]  px_o;

  ext_bus_iface dut_i (.*);

  int total = 0, bad = 0;
  bit started = 0;

  // behavioural reference
  logic        m_host;
  logic [3:0]  e_sel = 4'hF;
  logic        e_rd = 1, e_wr = 1, e_rv = 0;
  logic [13:0] e_addr = 0, e_aoe = 0;
  logic [23:0] e_dout = 0, e_doe = 0, e_rdata = 0;
  logic [7:0]  e_px = 0, p_wlow = 0;
  bit          pv = 0, pw = 0, cv = 0, cw = 0;
  int          psp = 0, csp = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_host = mode_strap;
      e_sel = 4'hF; e_rd = 1; e_wr = 1; e_addr = 0; e_aoe = 0; e_dout = 0; e_doe = 0;
      e_rv = 0; e_rdata = 0; e_px = 0; pv = 0; cv = 0;
    end else begin
      cv = pv; csp = psp; cw = pw;
      e_rv = pv && !pw;
      if (pv && !pw) begin
        if (psp == 0) e_rdata = m_host ? ((data_i & 24'hFFFF00) | 24'hFF) : data_i;
        else if (psp == 3) e_rdata = (data_i >> 8) & 24'hFF;
        else e_rdata = data_i >> 8;
      end
      if (pv && psp == 0) e_px = pw ? p_wlow : (m_host ? 8'hFF : data_i[7:0]);
      pv = req_valid; psp = req_space; pw = req_write; p_wlow = req_wdata[7:0];
      e_dout = 0; e_doe = 0; e_addr = 0; e_aoe = 0;
      e_sel = 4'hF; e_rd = 1; e_wr = 1;
      if (req_valid) begin
        e_sel = ~(4'b0001 << req_space);
        e_rd = req_write; e_wr = !req_write;
        if (m_host) begin e_addr = {13'h0, req_addr[0]}; e_aoe = 14'h1; end
        else begin e_addr = req_addr[13:0]; e_aoe = 14'h3FFF; end
        if (req_space == 3) begin
          e_dout = (m_host ? dm_page : req_addr[21:14]) * 24'h10000;
          e_doe = 24'hFF0000;
          if (req_write) begin
            e_dout = e_dout + req_wdata[7:0] * 24'h100;
            e_doe = 24'hFFFF00;
          end
        end else if (req_write) begin
          if (req_space == 0 && !m_host) begin e_dout = req_wdata; e_doe = 24'hFFFFFF; end
          else if (req_space == 0) begin e_dout = req_wdata & 24'hFFFF00; e_doe = 24'hFFFF00; end
          else begin e_dout = {req_wdata[15:0], 8'h00}; e_doe = 24'hFFFF00; end
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    string tp, tr, tx;
    if (!started) return;
    tp = (psp == 3) ? (m_host ? "R8" : "R4") : (m_host ? (psp == 0 ? "R6" : "R5") : "R3");
    tr = (cv && !cw && csp == 0) ? (m_host ? "R7" : "R10") : "R9";
    tx = (cv && csp == 0) ? (cw ? "R6" : (m_host ? "R7" : "R10")) : "R9";
    chk("R1", "host_mode", host_mode_o, m_host);
    chk("R2", "sel_n", sel_n_o, e_sel);
    chk("R2", "rd_n/wr_n", {rd_n_o, wr_n_o}, {e_rd, e_wr});
    chk(m_host ? "R5" : tp, "addr", addr_o, e_addr);
    chk(m_host ? "R5" : "R3", "addr_oe", addr_oe_o, e_aoe);
    chk(tp, "data_o", data_o & data_oe_o, e_dout);
    chk("R9", "data_oe", data_oe_o, e_doe);
    chk("R9", "rvalid", rdata_valid_o, e_rv);
    chk(tr, "rdata", rdata_o, e_rdata);
    chk(tx, "px", px_o, e_px);
  endtask

  task automatic step(input bit v, input int sp, input bit w, input logic [21:0] a, input logic [23:0] wd);
    @(negedge clk);
    compare();
    req_valid = v; req_space = sp[1:0]; req_write = w; req_addr = a; req_wdata = wd;
    data_i = data_i * 24'd5 + 24'h3A71;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 22'h0, 24'h0);
  endtask

  task automatic run_mode(input bit s);
    @(negedge clk);
    rst_n = 0; mode_strap = !s;
    idle(2);
    mode_strap = s;
    idle(1);
    started = 1;
    @(negedge clk);
    compare();          // reset state, R2
    rst_n = 1;
    mode_strap = !s;    // ignored after reset, R1
    step(1, 0, 1, 22'h000123, 24'hABCDEF);
    step(1, 0, 0, 22'h000124, 24'h0);
    step(1, 1, 1, 22'h002AAA, 24'h11BEEF);
    step(1, 1, 0, 22'h002AAB, 24'h0);
    step(1, 2, 1, 22'h001555, 24'h9C3D21);
    step(1, 2, 0, 22'h001554, 24'h0);
    dm_page = 8'hC3;
    step(1, 3, 1, 22'h3F1235, 24'h00005A);
    step(1, 3, 0, 22'h102468, 24'h0);
    dm_page = 8'h5E;
    step(1, 3, 0, 22'h2A0001, 24'h0);
    idle(1);
    step(1, 0, 0, 22'h003FFF, 24'h0);
    step(1, 0, 1, 22'h000001, 24'h7E8F90);
    step(1, 0, 0, 22'h000002, 24'h0);
    mode_strap = s;
    idle(3);
  endtask

  initial begin
    run_mode(1'b0);
    run_mode(1'b1);
    run_mode(1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule